// File: doc/BRIEF.md
# Page-Level Address Mapping Unit

This block keeps an on-chip translation table from logical page numbers to physical page numbers for a flash storage controller. Any logical page can sit in any physical page. A read lookup takes a logical page number and returns, one clock later, either the physical page that holds it or a miss flag if the page has never been written.

Writes are always out-of-place. An accepted write takes the next free erased physical page, and free pages are handed out in rising order from zero. The write points the table entry at that page, marks the page valid, and clears the valid bit of the page the entry used to name. The write response carries the new physical page and the logical page number to be programmed into that page's spare area. When the entry was already mapped, the response also carries an invalidate request naming the old physical page, so that its spare field can be marked.

Reclaiming pages is handled elsewhere. Once every physical page has been handed out, the unit raises a full flag and refuses further writes.

Top module: `pmap_unit`

## Requirements
- R1: After reset no logical page is mapped. No physical page is valid, `pool_full` is 0, and every response strobe (`rd_done`, `wr_done`, `inv_valid`) is 0.
- R2: A read request returns `rd_done`=1 on the following cycle. When the logical page is mapped, it also returns `rd_hit`=1 and `rd_ppn` equal to the physical page last assigned to that logical page.
- R3: A read of a logical page that has never been written gives `rd_hit`=0 and `rd_ppn`=0.
- R4: Accepted writes take physical pages in strictly increasing order, starting at 0 after reset, one page per write. The response on the next cycle gives `wr_done`=1, `wr_refused`=0, and the assigned page on `wr_ppn`.
- R5: On an accepted write, `spare_lpn` in the response equals the logical page number that was written.
- R6: A write to a logical page that was already mapped raises `inv_valid`=1 with `inv_ppn` equal to the previously mapped physical page. A first write to a logical page gives `inv_valid`=0.
- R7: `vq_valid` is combinational from `vq_ppn`. It is 1 exactly for physical pages that currently hold the live copy of some logical page. It is 0 for pages never allocated and for pages that have been superseded.
- R8: `pool_full` is 1 once all `PPN_COUNT` physical pages have been allocated, and it stays 1 until reset. A write while full responds with `wr_done`=1, `wr_refused`=1, `inv_valid`=0, `wr_ppn`=0 and `spare_lpn`=0, and it leaves every mapping and valid bit unchanged.
- R9: A read and a write to the same logical page in the same cycle return the mapping as it stood before that write.
- R10: A write changes only the entry of the logical page it names. All other logical pages keep their mappings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Lookup request |
| rd_lpn | input | LPN_W | Logical page to look up |
| wr_req | input | 1 | Write (remap) request |
| wr_lpn | input | LPN_W | Logical page being written |
| vq_ppn | input | PPN_W | Physical page whose valid bit is queried |
| rd_done | output | 1 | Lookup response strobe |
| rd_hit | output | 1 | Looked-up page is mapped |
| rd_ppn | output | PPN_W | Physical page of the lookup, 0 on miss |
| wr_done | output | 1 | Write response strobe |
| wr_refused | output | 1 | Write rejected because the pool is empty |
| wr_ppn | output | PPN_W | Newly assigned physical page |
| spare_lpn | output | LPN_W | Logical page number to store in the spare area |
| inv_valid | output | 1 | Invalidate request for an old copy |
| inv_ppn | output | PPN_W | Physical page to mark invalid |
| vq_valid | output | 1 | Valid bit of `vq_ppn` |
| pool_full | output | 1 | No free physical page remains |

## Verification
Directed sequences come first. They read an untouched page to exercise the miss path and write the same logical page twice to produce an invalidate. They issue a read and a write to one page in the same cycle, which separates the pre-write view from a forwarded one. Random mixes of reads and writes over a small logical space follow. These create many rewrites, and they check that unrelated entries and superseded valid bits stay as they were. The random mix keeps running after the pool is used up, and a final directed write confirms that a refusal changes neither the table nor the valid bits.

// File: rtl/pmap_pkg.sv
package pmap_pkg;

  typedef enum logic [1:0] {
    WK_IDLE   = 2'd0,
    WK_FIRST  = 2'd1,
    WK_MOVE   = 2'd2,
    WK_REFUSE = 2'd3
  } wr_kind_e;

  // Kind of write response, from request, pool state and prior mapping.
  function automatic wr_kind_e wr_classify(input logic req, input logic empty_pool,
                                           input logic had_old);
    if (!req)           return WK_IDLE;
    else if (empty_pool) return WK_REFUSE;
    else if (had_old)    return WK_MOVE;
    else                 return WK_FIRST;
  endfunction

  // True when the allocation count has reached the page count.
  function automatic logic pool_spent(input int unsigned used, input int unsigned total);
    return used >= total;
  endfunction

endpackage

// File: rtl/pmap_alloc.sv
module pmap_alloc #(
  parameter int PPN_COUNT = 32,
  localparam int PPN_W = $clog2(PPN_COUNT),
  localparam int CNT_W = PPN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  output logic [PPN_W-1:0] next_ppn,
  output logic [CNT_W-1:0] used_cnt,
  output logic             exhausted
);
  import pmap_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (take && !exhausted) cnt_q <= cnt_q + 1'b1;
  end

  assign used_cnt  = cnt_q;
  assign next_ppn  = cnt_q[PPN_W-1:0];
  assign exhausted = pool_spent(int'(cnt_q), PPN_COUNT);
endmodule

// File: rtl/pmap_table.sv
module pmap_table #(
  parameter int LPN_COUNT = 16,
  parameter int PPN_COUNT = 32,
  localparam int LPN_W = $clog2(LPN_COUNT),
  localparam int PPN_W = $clog2(PPN_COUNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LPN_W-1:0] rd_lpn,
  output logic             rd_mapped,
  output logic [PPN_W-1:0] rd_ppn,
  input  logic [LPN_W-1:0] wr_lpn,
  output logic             old_mapped,
  output logic [PPN_W-1:0] old_ppn,
  input  logic             upd_en,
  input  logic [PPN_W-1:0] upd_ppn
);
  logic [LPN_COUNT-1:0]            ent_map;
  logic [LPN_COUNT-1:0][PPN_W-1:0] ent_ppn;
  logic [LPN_COUNT-1:0]            ent_sel;

  for (genvar g = 0; g < LPN_COUNT; g++) begin : g_sel
    assign ent_sel[g] = upd_en && (wr_lpn == LPN_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_map <= '0;
      ent_ppn <= '0;
    end else begin
      for (int i = 0; i < LPN_COUNT; i++) begin
        if (ent_sel[i]) begin
          ent_map[i] <= 1'b1;
          ent_ppn[i] <= upd_ppn;
        end
      end
    end
  end

  assign rd_mapped  = ent_map[rd_lpn];
  assign rd_ppn     = ent_ppn[rd_lpn];
  assign old_mapped = ent_map[wr_lpn];
  assign old_ppn    = ent_ppn[wr_lpn];
endmodule

// File: rtl/pmap_bitmap.sv
module pmap_bitmap #(
  parameter int PPN_COUNT = 32,
  localparam int PPN_W = $clog2(PPN_COUNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [PPN_W-1:0] set_ppn,
  input  logic             clr_en,
  input  logic [PPN_W-1:0] clr_ppn,
  input  logic [PPN_W-1:0] q_ppn,
  output logic             q_valid,
  output logic [PPN_COUNT-1:0] bits
);
  logic [PPN_COUNT-1:0] vb_q;
  logic [PPN_COUNT-1:0] set_hit;
  logic [PPN_COUNT-1:0] clr_hit;

  for (genvar g = 0; g < PPN_COUNT; g++) begin : g_hit
    assign set_hit[g] = set_en && (set_ppn == PPN_W'(g));
    assign clr_hit[g] = clr_en && (clr_ppn == PPN_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vb_q <= '0;
    else        vb_q <= (vb_q & ~clr_hit) | set_hit;
  end

  assign q_valid = vb_q[q_ppn];
  assign bits    = vb_q;
endmodule

// File: rtl/pmap_unit.sv
module pmap_unit #(
  parameter int LPN_COUNT = 16,
  parameter int PPN_COUNT = 32,
  localparam int LPN_W = $clog2(LPN_COUNT),
  localparam int PPN_W = $clog2(PPN_COUNT),
  localparam int CNT_W = PPN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [LPN_W-1:0] rd_lpn,
  input  logic             wr_req,
  input  logic [LPN_W-1:0] wr_lpn,
  input  logic [PPN_W-1:0] vq_ppn,
  output logic             rd_done,
  output logic             rd_hit,
  output logic [PPN_W-1:0] rd_ppn,
  output logic             wr_done,
  output logic             wr_refused,
  output logic [PPN_W-1:0] wr_ppn,
  output logic [LPN_W-1:0] spare_lpn,
  output logic             inv_valid,
  output logic [PPN_W-1:0] inv_ppn,
  output logic             vq_valid,
  output logic             pool_full
);
  import pmap_pkg::*;

  // Named internal events for the checker.
  logic             alloc_take;
  logic [PPN_W-1:0] alloc_ppn;
  logic [CNT_W-1:0] alloc_count;
  logic             alloc_empty;
  logic             tbl_rd_mapped;
  logic [PPN_W-1:0] tbl_rd_ppn;
  logic             tbl_old_mapped;
  logic [PPN_W-1:0] tbl_old_ppn;
  logic [PPN_COUNT-1:0] valid_bits;
  wr_kind_e         wr_kind;

  assign wr_kind    = wr_classify(wr_req, alloc_empty, tbl_old_mapped);
  assign alloc_take = (wr_kind == WK_FIRST) || (wr_kind == WK_MOVE);

  pmap_alloc #(.PPN_COUNT(PPN_COUNT)) u_alloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (alloc_take),
    .next_ppn  (alloc_ppn),
    .used_cnt  (alloc_count),
    .exhausted (alloc_empty)
  );

  pmap_table #(.LPN_COUNT(LPN_COUNT), .PPN_COUNT(PPN_COUNT)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_lpn     (rd_lpn),
    .rd_mapped  (tbl_rd_mapped),
    .rd_ppn     (tbl_rd_ppn),
    .wr_lpn     (wr_lpn),
    .old_mapped (tbl_old_mapped),
    .old_ppn    (tbl_old_ppn),
    .upd_en     (alloc_take),
    .upd_ppn    (alloc_ppn)
  );

  pmap_bitmap #(.PPN_COUNT(PPN_COUNT)) u_bitmap (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (alloc_take),
    .set_ppn (alloc_ppn),
    .clr_en  (wr_kind == WK_MOVE),
    .clr_ppn (tbl_old_ppn),
    .q_ppn   (vq_ppn),
    .q_valid (vq_valid),
    .bits    (valid_bits)
  );

  // Lookup response: the table is read before this edge's update (same-cycle read sees old map).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_done <= 1'b0;
      rd_hit  <= 1'b0;
      rd_ppn  <= '0;
    end else begin
      rd_done <= rd_req;
      rd_hit  <= rd_req && tbl_rd_mapped;
      rd_ppn  <= (rd_req && tbl_rd_mapped) ? tbl_rd_ppn : '0;
    end
  end

  // Write response.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_done    <= 1'b0;
      wr_refused <= 1'b0;
      wr_ppn     <= '0;
      spare_lpn  <= '0;
      inv_valid  <= 1'b0;
      inv_ppn    <= '0;
    end else begin
      wr_done    <= (wr_kind != WK_IDLE);
      wr_refused <= (wr_kind == WK_REFUSE);
      wr_ppn     <= alloc_take ? alloc_ppn : '0;
      spare_lpn  <= alloc_take ? wr_lpn : '0;
      inv_valid  <= (wr_kind == WK_MOVE);
      inv_ppn    <= (wr_kind == WK_MOVE) ? tbl_old_ppn : '0;
    end
  end

  assign pool_full = alloc_empty;
endmodule

// File: rtl/pmap_unit_chk.sv
module pmap_unit_chk #(
  parameter int LPN_COUNT = 16,
  parameter int PPN_COUNT = 32,
  localparam int LPN_W = $clog2(LPN_COUNT),
  localparam int PPN_W = $clog2(PPN_COUNT),
  localparam int CNT_W = PPN_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_req,
  input logic             wr_req,
  input logic [LPN_W-1:0] wr_lpn,
  input logic             rd_done,
  input logic             rd_hit,
  input logic [PPN_W-1:0] rd_ppn,
  input logic             wr_done,
  input logic             wr_refused,
  input logic [PPN_W-1:0] wr_ppn,
  input logic [LPN_W-1:0] spare_lpn,
  input logic             inv_valid,
  input logic [PPN_W-1:0] inv_ppn,
  input logic             pool_full,
  input logic             alloc_take,
  input logic [CNT_W-1:0] alloc_count,
  input logic [PPN_COUNT-1:0] valid_bits
);
  assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> $past(rd_req));

  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !rd_hit) |-> (rd_ppn == '0));

  assert_alloc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_take |=> (alloc_count == $past(alloc_count) + 1'b1));

  assert_new_page_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && !wr_refused) |-> valid_bits[wr_ppn]);

  assert_spare_lpn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && !wr_refused) |-> (spare_lpn == $past(wr_lpn)));

  assert_inv_old_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (wr_done && !wr_refused && inv_ppn != wr_ppn && !valid_bits[inv_ppn]));

  assert_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pool_full && wr_req) |=> (wr_refused && !inv_valid));

  assert_full_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pool_full |=> (pool_full && $stable(valid_bits)));
endmodule

bind pmap_unit pmap_unit_chk #(.LPN_COUNT(LPN_COUNT), .PPN_COUNT(PPN_COUNT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_req      (rd_req),
  .wr_req      (wr_req),
  .wr_lpn      (wr_lpn),
  .rd_done     (rd_done),
  .rd_hit      (rd_hit),
  .rd_ppn      (rd_ppn),
  .wr_done     (wr_done),
  .wr_refused  (wr_refused),
  .wr_ppn      (wr_ppn),
  .spare_lpn   (spare_lpn),
  .inv_valid   (inv_valid),
  .inv_ppn     (inv_ppn),
  .pool_full   (pool_full),
  .alloc_take  (alloc_take),
  .alloc_count (alloc_count),
  .valid_bits  (valid_bits)
);

// File: tb/sim_pmap_unit.sv
module sim_pmap_unit;
  localparam int LN = 16;
  localparam int PN = 32;
  localparam int LW = $clog2(LN);
  localparam int PW = $clog2(PN);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_req = 1'b0;
  logic [LW-1:0] rd_lpn = '0;
  logic          wr_req = 1'b0;
  logic [LW-1:0] wr_lpn = '0;
  logic [PW-1:0] vq_ppn = '0;
  logic          rd_done, rd_hit, wr_done, wr_refused, inv_valid, vq_valid, pool_full;
  logic [PW-1:0] rd_ppn, wr_ppn, inv_ppn;
  logic [LW-1:0] spare_lpn;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // Reference state.
  bit m_map [LN];
  int m_ppn [LN];
  bit m_vld [PN];
  int m_next;

  always #5 clk = ~clk;

  pmap_unit #(.LPN_COUNT(LN), .PPN_COUNT(PN)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_lpn(rd_lpn), .wr_req(wr_req),
    .wr_lpn(wr_lpn), .vq_ppn(vq_ppn), .rd_done(rd_done), .rd_hit(rd_hit),
    .rd_ppn(rd_ppn), .wr_done(wr_done), .wr_refused(wr_refused), .wr_ppn(wr_ppn),
    .spare_lpn(spare_lpn), .inv_valid(inv_valid), .inv_ppn(inv_ppn),
    .vq_valid(vq_valid), .pool_full(pool_full));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lookup(input int lpn);
    return m_map[lpn] ? m_ppn[lpn] : 0;
  endfunction

  function automatic bit exp_full();
    return m_next >= PN;
  endfunction

  // One cycle of stimulus plus full response check.
  task automatic step(input bit rd, input int rl, input bit wr, input int wl, input int vq);
    bit e_hit, e_ref, e_inv;
    int e_rppn, e_wppn, e_ippn, e_spare;
    @(negedge clk);
    rd_req = rd; rd_lpn = LW'(rl); wr_req = wr; wr_lpn = LW'(wl); vq_ppn = PW'(vq);
    // Expected read result uses the map before this write (R9).
    e_hit  = rd && m_map[rl];
    e_rppn = rd ? exp_lookup(rl) : 0;
    e_ref = 0; e_inv = 0; e_wppn = 0; e_ippn = 0; e_spare = 0;
    if (wr) begin
      if (exp_full()) e_ref = 1;
      else begin
        e_wppn = m_next; e_spare = wl;
        if (m_map[wl]) begin e_inv = 1; e_ippn = m_ppn[wl]; m_vld[m_ppn[wl]] = 0; end
        m_map[wl] = 1; m_ppn[wl] = m_next; m_vld[m_next] = 1; m_next++;
      end
    end
    @(posedge clk); #1;
    chk("R2 rd_done", int'(rd_done), int'(rd));
    chk("R2/R3 rd_hit", int'(rd_hit), int'(e_hit));
    chk("R2/R3/R9 rd_ppn", int'(rd_ppn), e_rppn);
    chk("R4 wr_done", int'(wr_done), int'(wr));
    chk("R8 wr_refused", int'(wr_refused), int'(e_ref));
    chk("R4 wr_ppn", int'(wr_ppn), e_wppn);
    chk("R5 spare_lpn", int'(spare_lpn), e_spare);
    chk("R6 inv_valid", int'(inv_valid), int'(e_inv));
    chk("R6 inv_ppn", int'(inv_ppn), e_ippn);
    chk("R7 vq_valid", int'(vq_valid), int'(m_vld[vq]));
    chk("R8 pool_full", int'(pool_full), int'(exp_full()));
  endtask

  // Sweep every lookup and valid bit (R10 entries undisturbed, R7 bitmap).
  task automatic sweep();
    for (int l = 0; l < LN; l++) step(1, l, 0, 0, l);
    for (int p = LN; p < PN; p++) step(0, 0, 0, 0, p);
  endtask

  initial begin
    void'($urandom(32'd1147));
    for (int i = 0; i < LN; i++) begin m_map[i] = 0; m_ppn[i] = 0; end
    for (int i = 0; i < PN; i++) m_vld[i] = 0;
    m_next = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: reset state.
    chk("R1 pool_full", int'(pool_full), 0);
    chk("R1 rd_done", int'(rd_done), 0);
    chk("R1 wr_done", int'(wr_done), 0);
    chk("R1 inv_valid", int'(inv_valid), 0);
    for (int p = 0; p < PN; p++) begin
      vq_ppn = PW'(p); #1;
      chk("R1 vq_valid", int'(vq_valid), 0);
    end
    // R3: miss on untouched page.
    step(1, 3, 0, 0, 0);
    // R4/R5/R6: first write, then rewrite.
    step(0, 0, 1, 3, 0);
    step(1, 3, 0, 0, 0);
    step(0, 0, 1, 3, 0);
    step(0, 0, 0, 0, 0);  // R7: old page now invalid
    step(0, 0, 0, 0, 1);
    // R9: same-cycle read and write of one page.
    step(1, 3, 1, 3, 2);
    step(1, 3, 0, 0, 1);
    // R10: other page written, then full sweep.
    step(0, 0, 1, 15, 3);
    sweep();
    // Random mix, runs past exhaustion (R8).
    for (int k = 0; k < 120; k++)
      step(($urandom % 2) == 0, int'($urandom % LN), ($urandom % 3) != 0,
           int'($urandom % LN), int'($urandom % PN));
    // Directed refusal with same-cycle read; nothing may change (R8).
    step(1, 0, 1, 0, 0);
    step(0, 0, 1, 7, 5);
    sweep();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule